// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-interface master that lets software read and write PHY registers over a two-wire MDC/MDIO link. It sits behind a simple 32-bit register bus: a write strobe, a byte address and write data, with read data returned combinationally for the addressed word. The bidirectional MDIO line is split into separate out, output-enable and in signals, so a pad or a bench can build the open-drain line outside the block.

Software first loads one command word with the operation, PHY address, register address and write data. It then writes the same word again with the start bit set and polls that bit until hardware clears it. A separate configuration word selects the start-code flavour, the MDC divider and whether the 32-bit preamble is skipped. When a read completes, the command word's low 16 bits hold the value taken from the PHY. A sticky flag records a PHY that left the line high where it should have pulled it low during turnaround.

Top module: `mdio_master`

## Requirements
- R1: After reset the command word (byte offset 0x0) reads 0x00000000, the configuration word (byte offset 0x4) reads 0x00000001, MDC is low and the output enable is low.
- R2: Writing the command word with bit 29 set while idle starts a frame. Bit 29 reads 1 while the frame is in progress and returns to 0 by itself when the frame ends. MDC toggles only while bit 29 is 1.
- R3: The command word carries the operation in bits 27:26 (2'b10 read, 2'b01 write), the PHY address in bits 25:21, the register address in bits 20:16 and the data in bits 15:0. A write frame shifts out, MSB first and with the output enabled, 32 ones, the start code, the operation, PHY address, register address, turnaround 1,0 and 16 data bits.
- R4: With configuration bit 12 set, the 32 preamble ones are left out and the frame is 32 MDC cycles long. Otherwise it is 64 cycles long.
- R5: Configuration bit 0 picks the start code: 01 when it is 1, 00 when it is 0.
- R6: In a read frame the output enable is low for both turnaround bits and all 16 data bits. The 16 bits sampled on MDC rising edges, MSB first, appear in command bits 15:0 once bit 29 has cleared.
- R7: Command bit 28 becomes 1 if MDIO is high when sampled at the second turnaround bit of a read. It stays set after the frame and is cleared when the next frame is started.
- R8: Configuration bits 9:4 hold a divider D, and the MDC period is 2*(D+1) system clocks. MDIO out and output enable change only while MDC is low.
- R9: A command-word write while bit 29 is 1 is ignored. It neither changes the stored fields nor starts another frame.
- R10: The configuration word reads back bit 0, bits 9:4 and bit 12 as written. All its other bits read 0.
- R11: While no frame is in progress, MDC stays low and the output enable stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO drive enable, high while the master drives |
| mdio_in | input | 1 | Value sampled from MDIO |

## Verification
Frames are run in a mix of operation, start code, preamble setting and divider value. Reads alternate against writes, so the released turnaround and data window is told apart from a fully driven frame. Clause-22 frames are mixed with clause-45 ones and preamble frames with suppressed ones, which separates the start code from the 32-against-64 frame length. Several divider values and varied address and data patterns, including all-ones and single-bit words, expose field misplacement and a wrong MDC period. Directed cases cover a PHY that leaves turnaround high, a command rewritten mid-frame, and configuration readback with unused bits written to one.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DATA_W     = 32;
    localparam int DIV_W      = 6;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 64;
    localparam int POS_W      = $clog2(FRAME_BITS);
    // bit positions inside the full 64-bit frame
    localparam int TA_FIRST   = PRE_BITS + 14;
    localparam int TA_SECOND  = TA_FIRST + 1;
    localparam int DATA_FIRST = TA_FIRST + 2;

    localparam logic [3:0] CMD_OFS = 4'h0;
    localparam logic [3:0] CFG_OFS = 4'h4;
    localparam int START_BIT = 29;

    typedef enum logic [1:0] {
        OP_NONE0 = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_NONE3 = 2'b11
    } mdio_op_e;

    typedef struct packed {
        logic        busy;
        logic        fail;
        mdio_op_e    op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } cmd_t;

    typedef struct packed {
        logic             c22;
        logic             no_pre;
        logic [DIV_W-1:0] div;
    } cfg_t;

    function automatic logic [DATA_W-1:0] cmd_word(input cmd_t c);
        return {2'b00, c};
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(input cfg_t c);
        return {19'd0, c.no_pre, 2'b00, c.div, 3'b000, c.c22};
    endfunction

    function automatic cmd_t cmd_from_word(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.busy  = w[START_BIT];
        c.fail  = 1'b0;
        c.op    = mdio_op_e'(w[27:26]);
        c.phy   = w[25:21];
        c.regad = w[20:16];
        c.data  = w[15:0];
        return c;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input cmd_t c, input cfg_t g);
        logic [1:0] st;
        logic [1:0] ta;
        st = g.c22 ? 2'b01 : 2'b00;
        ta = (c.op == OP_READ) ? 2'b11 : 2'b10;
        return {{PRE_BITS{1'b1}}, st, c.op, c.phy, c.regad, ta, c.data};
    endfunction

endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [DIV_W-1:0] DIV_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              done,
    input  logic              fail_set,
    input  logic [15:0]       rx_data,
    output logic              start,
    output cmd_t              new_cmd,
    output cmd_t              cmd_q,
    output cfg_t              cfg_q
);

    logic cmd_sel;
    logic cfg_sel;
    logic cmd_take;

    assign cmd_sel  = (bus_addr == ADDR_W'(CMD_OFS));
    assign cfg_sel  = (bus_addr == ADDR_W'(CFG_OFS));
    assign cmd_take = bus_wr && cmd_sel && !cmd_q.busy;
    assign start    = cmd_take && bus_wdata[START_BIT];
    assign new_cmd  = cmd_from_word(bus_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (cmd_take) begin
            cmd_q.op    <= new_cmd.op;
            cmd_q.phy   <= new_cmd.phy;
            cmd_q.regad <= new_cmd.regad;
            cmd_q.data  <= new_cmd.data;
            if (start) begin
                cmd_q.busy <= 1'b1;
                cmd_q.fail <= 1'b0;
            end
        end else begin
            if (fail_set) begin
                cmd_q.fail <= 1'b1;
            end
            if (done) begin
                cmd_q.busy <= 1'b0;
                if (cmd_q.op == OP_READ) begin
                    cmd_q.data <= rx_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.c22    <= 1'b1;
            cfg_q.no_pre <= 1'b0;
            cfg_q.div    <= DIV_RST;
        end else if (bus_wr && cfg_sel) begin
            cfg_q.c22    <= bus_wdata[0];
            cfg_q.div    <= bus_wdata[4 +: DIV_W];
            cfg_q.no_pre <= bus_wdata[12];
        end
    end

    always_comb begin
        if (cmd_sel) begin
            bus_rdata = cmd_word(cmd_q);
        end else if (cfg_sel) begin
            bus_rdata = cfg_word(cfg_q);
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    logic [DIV_W-1:0] cnt;
    logic             tc;

    assign tc   = en && (cnt == div);
    assign rise = tc && !mdc;
    assign fall = tc && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tc) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  cmd_t             new_cmd,
    input  cfg_t             cfg,
    input  logic             rise,
    input  logic             fall,
    input  logic             mdio_in,
    output logic             active,
    output logic [DIV_W-1:0] div_q,
    output logic             mdio_out,
    output logic             mdio_oe,
    output logic             done,
    output logic             fail_set,
    output logic [15:0]      rx_data
);

    logic [FRAME_BITS-1:0] frame;
    logic [POS_W-1:0]      pos;
    logic                  is_rd;
    logic                  last;
    logic                  released;

    assign last     = (pos == POS_W'(FRAME_BITS - 1));
    assign released = is_rd && (pos >= POS_W'(TA_FIRST));
    assign done     = active && fall && last;
    assign fail_set = active && rise && is_rd && (pos == POS_W'(TA_SECOND)) && mdio_in;
    assign mdio_out = active ? frame[~pos] : 1'b1;
    assign mdio_oe  = active && !released;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            frame   <= '0;
            pos     <= '0;
            is_rd   <= 1'b0;
            div_q   <= '0;
            rx_data <= '0;
        end else if (start) begin
            active  <= 1'b1;
            frame   <= build_frame(new_cmd, cfg);
            pos     <= cfg.no_pre ? POS_W'(PRE_BITS) : '0;
            is_rd   <= (new_cmd.op == OP_READ);
            div_q   <= cfg.div;
            rx_data <= '0;
        end else if (active) begin
            if (rise && is_rd && (pos >= POS_W'(DATA_FIRST))) begin
                rx_data <= {rx_data[14:0], mdio_in};
            end
            if (fall) begin
                if (last) begin
                    active <= 1'b0;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [DIV_W-1:0] DIV_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);

    cmd_t             new_cmd;
    cmd_t             cmd_q;
    cfg_t             cfg_q;
    logic             start;
    logic             done;
    logic             fail_set;
    logic [15:0]      rx_data;
    logic             active;
    logic [DIV_W-1:0] div_q;
    logic             rise;
    logic             fall;
    logic             busy;
    logic             wr_cmd;

    assign busy   = cmd_q.busy;
    assign wr_cmd = bus_wr && (bus_addr == ADDR_W'(CMD_OFS));

    mdio_regs #(.ADDR_W(ADDR_W), .DIV_RST(DIV_RST)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .done     (done),
        .fail_set (fail_set),
        .rx_data  (rx_data),
        .start    (start),
        .new_cmd  (new_cmd),
        .cmd_q    (cmd_q),
        .cfg_q    (cfg_q)
    );

    mdio_clkgen u_clk (
        .clk (clk),
        .rst (rst),
        .en  (active),
        .div (div_q),
        .mdc (mdc),
        .rise(rise),
        .fall(fall)
    );

    mdio_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .new_cmd (new_cmd),
        .cfg     (cfg_q),
        .rise    (rise),
        .fall    (fall),
        .mdio_in (mdio_in),
        .active  (active),
        .div_q   (div_q),
        .mdio_out(mdio_out),
        .mdio_oe (mdio_oe),
        .done    (done),
        .fail_set(fail_set),
        .rx_data (rx_data)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        start,
    input logic        wr_cmd,
    input logic        fail,
    input logic [11:0] fields,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe)); // R11

    AST_LINE_HOLD_MDC_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe))); // R8

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_cmd) |=> $stable(fields)); // R9

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !fail)); // R2

    AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> busy); // R2

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(fail) && !$past(start)) |-> fail); // R7

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .start   (start),
    .wr_cmd  (wr_cmd),
    .fail    (cmd_q.fail),
    .fields  ({cmd_q.op, cmd_q.phy, cmd_q.regad}),
    .mdc     (mdc),
    .mdio_out(mdio_out),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in = 1'b1;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = !clk;

    mdio_master u_mdio_master (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // fields: op(2) phy(5) reg(5) wdata(16) c22(1) nopre(1) div(6) phy_rd(16) ta(1)
    localparam int NV = 6;
    localparam logic [52:0] VEC [NV] = '{
        {2'b01, 5'd3,  5'h1F, 16'hA5C3, 1'b1, 1'b0, 6'd1, 16'h0000, 1'b0},
        {2'b10, 5'd1,  5'h01, 16'h0000, 1'b1, 1'b0, 6'd0, 16'h796D, 1'b0},
        {2'b01, 5'h1F, 5'h00, 16'h0001, 1'b0, 1'b1, 6'd2, 16'h0000, 1'b0},
        {2'b10, 5'h10, 5'h0E, 16'h0000, 1'b1, 1'b1, 6'd3, 16'h8001, 1'b0},
        {2'b10, 5'h05, 5'h1A, 16'h0000, 1'b0, 1'b0, 6'd0, 16'h1234, 1'b0},
        {2'b01, 5'h0A, 5'h15, 16'h5A5A, 1'b0, 1'b1, 6'd5, 16'h0000, 1'b0}
    };

    // PHY model state
    int          bitn = 0;
    logic        cap_oe  [64];
    logic        cap_out [64];
    time         t_rise [2];
    bit          phy_rd = 0;
    int          phy_h = 0;
    logic [15:0] phy_val = '0;
    logic        phy_ta = 1'b0;

    always @(posedge mdc) begin
        if (bitn < 64) begin
            cap_oe[bitn]  = mdio_oe;
            cap_out[bitn] = mdio_out;
        end
        if (bitn < 2) t_rise[bitn] = $time;
        bitn = bitn + 1;
    end

    always @(negedge mdc) begin
        int idx;
        idx = bitn;
        if (phy_rd && idx == phy_h + 15)
            mdio_in = phy_ta;
        else if (phy_rd && idx >= phy_h + 16 && idx < phy_h + 32)
            mdio_in = phy_val[15 - (idx - phy_h - 16)];
        else
            mdio_in = 1'b1;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(output logic [31:0] d);
        for (int i = 0; i < 20000; i++) begin
            bus_read(4'h0, d);
            if (!d[29]) break;
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] wd,
                                              input logic c22);
        return {32'hFFFFFFFF, (c22 ? 2'b01 : 2'b00), op, phy, rg, 2'b10, wd};
    endfunction

    task automatic run_vec(input logic [52:0] v);
        logic [1:0]  op;  logic [4:0] phy; logic [4:0] rg; logic [15:0] wd;
        logic c22; logic nopre; logic [5:0] dv; logic [15:0] rv; logic ta;
        logic [31:0] cmdw; logic [31:0] d; logic [63:0] ef;
        int nbits; int st; int bad_out; int bad_oe;
        {op, phy, rg, wd, c22, nopre, dv, rv, ta} = v;
        bus_write(4'h4, {19'd0, nopre, 2'b00, dv, 3'b000, c22});
        cmdw = {4'b0000, op, phy, rg, wd};
        bus_write(4'h0, cmdw);
        phy_rd = (op == 2'b10); phy_h = nopre ? 0 : 32; phy_val = rv; phy_ta = ta;
        bitn = 0; mdio_in = 1'b1;
        bus_write(4'h0, cmdw | 32'h2000_0000);
        bus_read(4'h0, d);
        check("R2 busy while running", {31'd0, d[29]}, 32'd1);
        wait_idle(d);
        check("R2 busy self-clears", {31'd0, d[29]}, 32'd0);
        nbits = nopre ? 32 : 64;
        check("R4 frame length", bitn, nbits);
        check("R8 MDC period", 32'(t_rise[1] - t_rise[0]), 32'(40 * (dv + 1)));
        ef = exp_frame(op, phy, rg, wd, c22);
        st = nopre ? 32 : 0;
        bad_out = 0; bad_oe = 0;
        for (int j = 0; j < nbits && j < 64; j++) begin
            int p;
            logic eoe;
            p = st + j;
            eoe = !(op == 2'b10 && p >= 46);
            if (cap_oe[j] !== eoe) bad_oe++;
            if (eoe && cap_out[j] !== ef[63 - p]) bad_out++;
        end
        if (op == 2'b10) begin
            check("R6 output enable pattern", bad_oe, 0);
            check("R3 R5 read header bits", bad_out, 0);
            check("R6 read data", d, {4'b0000, op, phy, rg, rv});
        end else begin
            check("R3 write enable pattern", bad_oe, 0);
            check("R3 R5 write frame bits", bad_out, 0);
            check("R3 command after write", d, cmdw);
        end
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bus_read(4'h0, d);
        check("R1 command reset", d, 32'h0);
        bus_read(4'h4, d);
        check("R1 config reset", d, 32'h1);
        check("R1 R11 idle pins", {30'd0, mdc, mdio_oe}, 32'd0);

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);
        check("R11 idle after frames", {30'd0, mdc, mdio_oe}, 32'd0);

        // R10 config readback and unused bits
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_read(4'h4, d);
        check("R10 config all ones", d, 32'h0000_13F1);
        bus_write(4'h4, 32'h0000_0020);
        bus_read(4'h4, d);
        check("R10 config divider only", d, 32'h0000_0020);

        // R7 read-fail on a PHY leaving turnaround high
        bus_write(4'h4, 32'h0000_1001);
        phy_rd = 1; phy_h = 0; phy_val = 16'hFFFF; phy_ta = 1'b1;
        bitn = 0; mdio_in = 1'b1;
        bus_write(4'h0, 32'h2842_0000);
        wait_idle(d);
        check("R7 fail flag set", {31'd0, d[28]}, 32'd1);
        check("R6 captured ones", {16'd0, d[15:0]}, 32'h0000_FFFF);
        phy_rd = 0; bitn = 0;
        bus_write(4'h0, 32'h2442_1111);
        bus_read(4'h0, d);
        check("R7 fail cleared on start", {30'd0, d[29:28]}, 32'd2);

        // R9 command write while busy
        wait_idle(d);
        check("R7 no fail after write", {31'd0, d[28]}, 32'd0);
        phy_rd = 0; phy_h = 0; bitn = 0;
        bus_write(4'h0, 32'h2463_BEEF);
        repeat (10) @(negedge clk);
        bus_write(4'h0, 32'h2BFF_0000);
        wait_idle(d);
        check("R9 fields kept", d, 32'h0463_BEEF);
        repeat (200) @(negedge clk);
        check("R9 no second frame", bitn, 32);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule